// File: doc/BRIEF.md
# Serial Frame CRC-32 Checker with Trailing-Bit Truncation

This block sits behind a physical-layer style receive path that delivers a frame one bit per clock, qualified by a valid strobe. It gathers the bits into octets, least significant bit first. Each completed octet passes through a CRC-32 register that advances eight bit positions in a single clock. When the valid strobe drops, any bits that did not fill a whole octet are dropped. These trailing "dribble" bits never reach the CRC. The frame check field is therefore always the last four complete octets, not the last 32 bits seen on the wire.

The register is loaded with all ones at the start of every frame. It uses the multiply-and-divide form of the update, so no zero padding is ever shifted in. When data and check octets have both passed through, a good frame leaves a single known residue in the register. One clock after the frame ends, the block gives a one-cycle result: a done strobe, a pass flag, a flag saying whether trailing bits were dropped, and the number of complete octets received. A new frame may begin on that same result cycle.

Top module: `frame_fcs_checker`

## Requirements
- R1: While `rx_valid` is high, one bit of `rx_bit` is taken per clock. Bits are packed into octets least significant bit first, so the first bit received becomes bit 0 of its octet.
- R2: When `rx_valid` falls, any 1 to 7 bits that do not complete an octet are discarded and have no effect on the CRC or on `fcs_ok`.
- R3: The check field is the last four complete octets. A frame whose complete octets carry a correct check sequence passes even when dribble bits follow them.
- R4: The CRC register advances once per completed octet, using the reflected generator 0xEDB88320 (0x04C11DB7 in normal bit order). The check sequence is the complement of the register, sent low byte first and each byte LSB first.
- R5: The CRC register is preset to all ones at the start of every frame. A frame that follows another frame directly, with one idle clock between them, is judged independently of the earlier one.
- R6: A frame passes only when the register, in its reflected form, holds the residue 0xDEBB20E3 after the last complete octet. That is 0xC704DD7B read in the opposite bit order. Any single-bit error in the complete octets makes the frame fail.
- R7: `fcs_ok` is never high unless `frame_done` is high.
- R8: `octet_count` on the result cycle equals the number of complete octets in the frame, including the check octets.
- R9: A frame with fewer than four complete octets is reported with `fcs_ok` low.
- R10: `dribble` is high on the result cycle exactly when 1 to 7 bits were discarded, and it is never high without `frame_done`.
- R11: `frame_done` is high for exactly one clock, the cycle after the first clock in which `rx_valid` is sampled low after a frame. Outside that cycle `fcs_ok`, `dribble` and `octet_count` are zero.
- R12: While `rst_n` is low, and after reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | High while frame bits are being delivered |
| rx_bit | input | 1 | Serial frame bit, sampled when `rx_valid` is high |
| frame_done | output | 1 | One-cycle strobe marking the result cycle |
| fcs_ok | output | 1 | Frame check passed (result cycle only) |
| dribble | output | 1 | Trailing partial octet was discarded (result cycle only) |
| octet_count | output | COUNT_W | Complete octets received (result cycle only) |

## Verification
A corrupted CRC register or a missed preset never shows up during a frame. It first appears as a wrong `fcs_ok` on the result cycle of the frame that was hit, or of the frame after it. Back-to-back frames are therefore used to expose stale register state one frame later. A slip in the bit counter of the octet packer shows up in two ways: a wrong `octet_count` and a wrong `dribble` flag on that same result cycle, together with a failing check on frames that should pass. Frames that carry a good check field followed by dribble bits tell apart truncation to whole octets and a "last 32 bits" check, because only the former passes them.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
    localparam int OCTET_BITS = 8;
    localparam int CRC_W      = 32;
    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [CRC_W-1:0] CRC_PRESET    = '1;
    localparam logic [CRC_W-1:0] CRC_RESIDUE   = 32'hDEBB20E3;
    localparam int MIN_OCTETS = 4;

    // Advance the reflected CRC register by one whole octet (LSB first).
    function automatic logic [CRC_W-1:0] crc_step_octet(
        input logic [CRC_W-1:0]      crc_in,
        input logic [OCTET_BITS-1:0] octet
    );
        logic [CRC_W-1:0] c;
        c = crc_in;
        for (int i = 0; i < OCTET_BITS; i++) begin
            if (c[0] ^ octet[i]) c = (c >> 1) ^ CRC_POLY_REFL;
            else                 c = c >> 1;
        end
        return c;
    endfunction
endpackage

// File: rtl/fcs_octet_packer.sv
module fcs_octet_packer
    import fcs_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rx_valid,
    input  logic                          rx_bit,
    output logic                          oct_stb,
    output logic [OCTET_BITS-1:0]         oct_data,
    output logic [$clog2(OCTET_BITS)-1:0] tail_bits
);
    localparam int CNT_W = $clog2(OCTET_BITS);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(OCTET_BITS - 1);

    typedef struct packed {
        logic [OCTET_BITS-1:0] shreg;
        logic [CNT_W-1:0]      cnt;
    } pack_t;

    pack_t st_d, st_q;
    logic [OCTET_BITS-1:0] assembled;

    always_comb begin
        st_d      = st_q;
        oct_stb   = 1'b0;
        assembled = {rx_bit, st_q.shreg[OCTET_BITS-1:1]};
        if (rx_valid) begin
            st_d.shreg = assembled;
            if (st_q.cnt == LAST_POS) begin
                oct_stb  = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            // partial octet is thrown away when the frame ends
            st_d.cnt = '0;
        end
    end

    assign oct_data  = assembled;
    assign tail_bits = st_q.cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: an idle cycle leaves no partial octet behind
    assert_tail_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rx_valid) |-> (tail_bits == '0));
    // R1: an octet completes only on a clock in which a bit is taken
    assert_stb_with_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        oct_stb |-> (rx_valid && $past(rx_valid)));
endmodule

// File: rtl/fcs_crc_engine.sv
module fcs_crc_engine
    import fcs_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  oct_stb,
    input  logic [OCTET_BITS-1:0] oct_data,
    input  logic                  frame_end,
    output logic [CRC_W-1:0]      crc_state
);
    typedef struct packed {
        logic [CRC_W-1:0] crc;
    } crc_st_t;

    crc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_end)    st_d.crc = CRC_PRESET;
        else if (oct_stb) st_d.crc = crc_step_octet(st_q.crc, oct_data);
    end

    assign crc_state = st_q.crc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{crc: CRC_PRESET};
        else        st_q <= st_d;
    end

    // R5: the register is preset for the next frame once a frame ends
    assert_preset_after_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (crc_state == CRC_PRESET));
    // R4: without a completed octet the register holds its value
    assert_hold_between_octets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!oct_stb && !frame_end) |=> $stable(crc_state));
endmodule

// File: rtl/frame_fcs_checker.sv
module frame_fcs_checker
    import fcs_pkg::*;
#(
    parameter int COUNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_valid,
    input  logic               rx_bit,
    output logic               frame_done,
    output logic               fcs_ok,
    output logic               dribble,
    output logic [COUNT_W-1:0] octet_count
);
    localparam int TAIL_W = $clog2(OCTET_BITS);
    localparam logic [COUNT_W-1:0] COUNT_MAX = '1;
    localparam logic [COUNT_W-1:0] COUNT_MIN = COUNT_W'(MIN_OCTETS);

    typedef struct packed {
        logic               in_frame;
        logic [COUNT_W-1:0] octets;
        logic               done;
        logic               ok;
        logic               drib;
        logic [COUNT_W-1:0] count;
    } top_t;

    top_t st_d, st_q;

    logic                  oct_stb;
    logic [OCTET_BITS-1:0] oct_data;
    logic [TAIL_W-1:0]     tail_bits;
    logic [CRC_W-1:0]      crc_state;
    logic                  frame_end;

    fcs_octet_packer u_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_bit    (rx_bit),
        .oct_stb   (oct_stb),
        .oct_data  (oct_data),
        .tail_bits (tail_bits)
    );

    fcs_crc_engine u_crc (
        .clk       (clk),
        .rst_n     (rst_n),
        .oct_stb   (oct_stb),
        .oct_data  (oct_data),
        .frame_end (frame_end),
        .crc_state (crc_state)
    );

    assign frame_end = st_q.in_frame && !rx_valid;

    always_comb begin
        st_d          = st_q;
        st_d.in_frame = rx_valid;
        st_d.done     = frame_end;
        st_d.ok       = 1'b0;
        st_d.drib     = 1'b0;
        st_d.count    = '0;
        if (frame_end) begin
            st_d.ok     = (st_q.octets >= COUNT_MIN) && (crc_state == CRC_RESIDUE);
            st_d.drib   = (tail_bits != '0);
            st_d.count  = st_q.octets;
            st_d.octets = '0;
        end else if (oct_stb && st_q.octets != COUNT_MAX) begin
            st_d.octets = st_q.octets + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frame_done  = st_q.done;
    assign fcs_ok      = st_q.ok;
    assign dribble     = st_q.drib;
    assign octet_count = st_q.count;

    assert_ok_needs_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fcs_ok |-> frame_done);
    assert_short_frame_fails_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && octet_count < COUNT_MIN) |-> !fcs_ok);
    assert_dribble_needs_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dribble |-> frame_done);
    assert_done_single_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
    assert_count_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |-> (octet_count == '0));
endmodule

// File: tb/frame_fcs_checker_test.sv
module frame_fcs_checker_test;
    localparam int CLK_PERIOD = 10;
    localparam int COUNT_W    = 16;
    localparam logic [31:0] POLY = 32'hEDB88320;

    // vector: {payload octets[8], seed[8], dribble bits[4], corrupt[1], append fcs[1]}
    localparam int NVEC = 9;
    localparam logic [21:0] VEC [0:NVEC-1] = '{
        {8'd46, 8'h11, 4'd0, 1'b0, 1'b1},
        {8'd46, 8'h11, 4'd3, 1'b0, 1'b1},
        {8'd1,  8'h52, 4'd7, 1'b0, 1'b1},
        {8'd0,  8'h00, 4'd0, 1'b0, 1'b1},
        {8'd20, 8'h9A, 4'd0, 1'b1, 1'b1},
        {8'd20, 8'h9A, 4'd5, 1'b1, 1'b1},
        {8'd3,  8'h07, 4'd0, 1'b0, 1'b0},
        {8'd0,  8'h00, 4'd6, 1'b0, 1'b0},
        {8'd60, 8'hC3, 4'd1, 1'b0, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 1'b0;
    logic rx_bit = 1'b0;
    logic frame_done, fcs_ok, dribble;
    logic [COUNT_W-1:0] octet_count;

    int checks = 0;
    int fails  = 0;

    logic fb [0:1023];
    int   nb;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_fcs_checker #(.COUNT_W(COUNT_W)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_valid    (rx_valid),
        .rx_bit      (rx_bit),
        .frame_done  (frame_done),
        .fcs_ok      (fcs_ok),
        .dribble     (dribble),
        .octet_count (octet_count)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push_bit(input logic b);
        fb[nb] = b;
        nb++;
    endtask

    // builds the frame bit stream; CRC computed here bit by bit
    task automatic build(input int n, input logic [7:0] seed, input int drib,
                         input bit corrupt, input bit with_fcs);
        logic [31:0] c;
        logic [31:0] fcs;
        logic [7:0]  b;
        c  = '1;
        nb = 0;
        for (int i = 0; i < n; i++) begin
            b = 8'((seed * (i + 1)) ^ (i * 7) ^ 8'h5A);
            for (int k = 0; k < 8; k++) begin
                push_bit(b[k]);
                if (c[0] ^ b[k]) c = (c >> 1) ^ POLY;
                else             c = c >> 1;
            end
        end
        fcs = ~c;
        if (with_fcs)
            for (int k = 0; k < 32; k++) push_bit(fcs[k]);
        if (corrupt && nb > 0) fb[nb/2] = ~fb[nb/2];
        for (int k = 0; k < drib; k++) push_bit((k % 2) == 0);
    endtask

    // sends the built frame, drops valid for one clock, checks the result cycle
    task automatic send_check(input string tag, input bit exp_ok,
                              input bit exp_drib, input int exp_cnt);
        for (int k = 0; k < nb; k++) begin
            rx_valid = 1'b1;
            rx_bit   = fb[k];
            @(negedge clk);
            if (k == 0) chk({tag, " R11 no done mid-frame"}, 32'(frame_done), 32'd0);
        end
        rx_valid = 1'b0;
        rx_bit   = 1'b0;
        @(negedge clk);
        chk({tag, " R11 done strobe"}, 32'(frame_done), 32'd1);
        chk({tag, " R3 R6 R9 pass flag"}, 32'(fcs_ok), 32'(exp_ok));
        chk({tag, " R2 R10 dribble flag"}, 32'(dribble), 32'(exp_drib));
        chk({tag, " R8 octet count"}, 32'(octet_count), 32'(exp_cnt));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired (R11) actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R12: reset state
        @(negedge clk);
        chk("R12 done in reset", 32'(frame_done), 32'd0);
        chk("R12 count in reset", 32'(octet_count), 32'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 done after reset", 32'(frame_done), 32'd0);
        chk("R12 pass after reset", 32'(fcs_ok), 32'd0);
        chk("R12 dribble after reset", 32'(dribble), 32'd0);

        // table walk; frames run back to back with one idle clock (R5, R1, R4)
        for (int v = 0; v < NVEC; v++) begin
            int  n;
            int  drib;
            bit  cor, wf;
            int  cnt;
            n    = int'(VEC[v][21:14]);
            drib = int'(VEC[v][5:2]);
            cor  = VEC[v][1];
            wf   = VEC[v][0];
            cnt  = n + (wf ? 4 : 0);
            build(n, VEC[v][13:6], drib, cor, wf);
            send_check($sformatf("vec%0d R5", v), wf && !cor && cnt >= 4, drib != 0, cnt);
        end

        // R11: pulse lasts one clock and fields return to zero
        @(negedge clk);
        chk("R11 done drops", 32'(frame_done), 32'd0);
        chk("R11 count zero when idle", 32'(octet_count), 32'd0);

        // R5: corrupted frame directly followed by good frame
        build(12, 8'h3C, 0, 1'b1, 1'b1);
        send_check("r5_bad_first", 1'b0, 1'b0, 16);
        build(12, 8'h3C, 0, 1'b0, 1'b1);
        send_check("r5_good_after_bad", 1'b1, 1'b0, 16);

        // R2: error only in discarded tail bits has no effect
        build(8, 8'h21, 4, 1'b0, 1'b1);
        fb[nb-1] = ~fb[nb-1];
        fb[nb-3] = ~fb[nb-3];
        send_check("r2_tail_flip", 1'b1, 1'b1, 12);

        // R1: bit order within octets matters; swapped first bits must fail
        build(8, 8'h77, 0, 1'b0, 1'b1);
        begin
            logic t;
            t = fb[0]; fb[0] = fb[1]; fb[1] = t;
            if (fb[0] == fb[1]) begin fb[0] = ~fb[0]; end
        end
        send_check("r1_order", 1'b0, 1'b0, 12);

        // R9: exactly three octets with fcs-like content still fails
        build(3, 8'h00, 0, 1'b0, 1'b0);
        send_check("r9_three_octets", 1'b0, 1'b0, 3);

        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule